// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block keeps the lifecycle state of a set of interrupt lines (32 by default) and tells a core which line to take next. Every line owns an enable bit, a pending bit, an active bit and an 8-bit priority. Peripherals raise requests on level inputs. A rising edge on an input marks that line pending. The core reads and changes state through a small word-addressed register bus. The core also reports when it enters a handler and when it returns from one, each as a one-cycle pulse that carries a line index.

The block sends the core a request flag with a line index and that line's priority. The line chosen is the best enabled pending line, and it is offered only when it outranks every line that is already active. A line can be active and pending at the same time. A line that is still pending and enabled when it returns is offered again. Pending status is latched even while a line is disabled, so enabling that line later makes it request at once. Software can drop a repeat instance during service by clearing pending before it returns.

Top module: `irq_lifecycle_tracker`

## Requirements
- R1: A rising edge on `irq_in[i]` (low in the previous cycle, high now) sets pending bit i on that clock edge. An input held high sets pending only once, so a pending bit cleared while the input stays high remains clear.
- R2: A write to the set-pending word (address 0x08) sets pending for each data bit that is 1, in the same way a hardware edge would. Data bits that are 0 have no effect. A write of 0 to set-pending, clear-pending or clear-enable leaves all state unchanged.
- R3: A write to the clear-pending word (address 0x0C) clears pending for each data bit that is 1. If a rising edge arrives on the same line in the same cycle, the edge wins and the line stays pending.
- R4: An entry pulse (`ack_valid` with `ack_id`) clears that line's pending bit and sets its active bit on the same clock edge.
- R5: A new request on a line that is already active sets its pending bit again, so the line is then both pending and active.
- R6: A return pulse (`ret_valid` with `ret_id`) clears that line's active bit. If the line is still pending and enabled, it is presented again on the next cycle.
- R7: Pending bits are recorded while a line is disabled and do not cause a request. Setting the enable bit of a line that is pending (address 0x00 sets, 0x04 clears) raises the request on the next cycle.
- R8: If pending is cleared while a line is active, the return pulse for that line does not lead to a second presentation of it.
- R9: Among the lines that are both enabled and pending, the one with the numerically lowest priority value is presented. Ties go to the lowest index. `irq_prio` carries that line's priority.
- R10: The chosen line is presented only when its priority value is strictly lower than the priority value of every active line. An equal value does not preempt.
- R11: Both enable addresses (0x00 and 0x04) read back the enable bits. Both pending addresses (0x08 and 0x0C) read back the pending bits. Address 0x10 reads the active bits, and writes to it are ignored. Read data appears on `bus_rdata` one cycle after the read. Bit b of the word at base+w maps to line 32*w+b, with w at most 3.
- R12: After a synchronous active-low reset, all enable, pending and active bits are 0, every priority is 0 and `irq_req` is low.
- R13: Address 0x80+k holds the priority of line k. The priority is written from the low 8 data bits and read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | N_LINES | Peripheral request levels; rising edge marks pending |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| ack_valid | input | 1 | Core entered the handler for `ack_id` |
| ack_id | input | $clog2(N_LINES) | Line being entered |
| ret_valid | input | 1 | Core returned from the handler for `ret_id` |
| ret_id | input | $clog2(N_LINES) | Line returning |
| irq_req | output | 1 | A line is offered to the core |
| irq_id | output | $clog2(N_LINES) | Index of the offered line |
| irq_prio | output | PRIO_W | Priority of the offered line |

## Verification
A wrong pending or enable bit shows up in the cycle after the faulty edge, either as a request that should not be there or as a missing request. It also shows on the next read of the pending or enable word. A stuck active bit is harder to see directly: its first visible effect is that lines of equal or lower urgency stay masked after the matching return. The bench therefore follows every entry and return with a check of the request outputs in the very next cycle. Mistakes in arbitration order appear only when several enabled lines are pending together, so those cases are set up with deliberate ties and with lines that differ only in priority.

// File: rtl/irq_pkg.sv
// Package: shared constants and the bus region code for the interrupt tracker.
// Assumes a word-addressed bus of 8 address bits and 32 data bits.
package irq_pkg;
    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;
    localparam int MAX_WORDS = 4;

    // Region selected by addr[4:2] when addr[7:5] is zero.
    typedef enum logic [2:0] {
        RG_EN_SET = 3'd0,
        RG_EN_CLR = 3'd1,
        RG_PD_SET = 3'd2,
        RG_PD_CLR = 3'd3,
        RG_ACTIVE = 3'd4
    } irq_region_e;
endpackage

// File: rtl/irq_bus_decode.sv
// Module: decodes bus writes into per-line set/clear masks and priority write
// strobes, and returns registered read data one cycle after a read.
// Assumes N_LINES <= 128 and one access per cycle.
module irq_bus_decode
    import irq_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int PRIO_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_valid,
    input  logic                      bus_write,
    input  logic [BUS_AW-1:0]         bus_addr,
    input  logic [BUS_DW-1:0]         bus_wdata,
    input  logic [N_LINES-1:0]        en_q,
    input  logic [N_LINES-1:0]        pend_q,
    input  logic [N_LINES-1:0]        act_q,
    input  logic [N_LINES*PRIO_W-1:0] prio_flat,
    output logic [N_LINES-1:0]        en_set,
    output logic [N_LINES-1:0]        en_clr,
    output logic [N_LINES-1:0]        pd_set,
    output logic [N_LINES-1:0]        pd_clr,
    output logic [N_LINES-1:0]        prio_we,
    output logic [PRIO_W-1:0]         prio_wdata,
    output logic [BUS_DW-1:0]         bus_rdata
);
    logic        wr;
    logic        bit_region;
    logic        prio_sel;
    irq_region_e region;
    logic [1:0]  word;
    logic [6:0]  prio_line;
    logic [BUS_DW-1:0] rd_val;

    // Split the address into region, word and priority-line fields.
    always_comb begin
        wr         = bus_valid & bus_write;
        bit_region = (bus_addr[7:5] == 3'b000);
        prio_sel   = bus_addr[7];
        region     = irq_region_e'(bus_addr[4:2]);
        word       = bus_addr[1:0];
        prio_line  = bus_addr[6:0];
    end

    assign prio_wdata = bus_wdata[PRIO_W-1:0];

    // One decode slice per line: bit position comes from the line index.
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        localparam int WI = i / 32;
        localparam int BI = i % 32;
        localparam int LI = i;
        logic hit;
        assign hit        = wr && bit_region && (word == WI[1:0]) && bus_wdata[BI];
        assign en_set[i]  = hit && (region == RG_EN_SET);
        assign en_clr[i]  = hit && (region == RG_EN_CLR);
        assign pd_set[i]  = hit && (region == RG_PD_SET);
        assign pd_clr[i]  = hit && (region == RG_PD_CLR);
        assign prio_we[i] = wr && prio_sel && (prio_line == LI[6:0]);
    end

    // Read multiplexer over bit words and the priority table.
    always_comb begin
        logic [N_LINES-1:0] src;
        int pl;
        rd_val = '0;
        src    = '0;
        pl     = int'(prio_line);
        if (prio_sel) begin
            if (pl < N_LINES) rd_val[PRIO_W-1:0] = prio_flat[pl*PRIO_W +: PRIO_W];
        end else if (bit_region) begin
            case (region)
                RG_EN_SET, RG_EN_CLR: src = en_q;
                RG_PD_SET, RG_PD_CLR: src = pend_q;
                RG_ACTIVE:            src = act_q;
                default:              src = '0;
            endcase
            for (int b = 0; b < BUS_DW; b++) begin
                if (int'(word) * 32 + b < N_LINES) rd_val[b] = src[int'(word) * 32 + b];
            end
        end
    end

    // Capture read data on a read access.
    always_ff @(posedge clk) begin
        if (!rst_n)                       bus_rdata <= '0;
        else if (bus_valid && !bus_write) bus_rdata <= rd_val;
    end

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));
endmodule

// File: rtl/irq_line_bank.sv
// Module: holds enable, pending, active and priority state for every line,
// detects rising edges on the request inputs and applies entry and return.
// Assumes at most one bus access per cycle, so set and clear never collide.
module irq_line_bank #(
    parameter int N_LINES = 32,
    parameter int PRIO_W  = 8,
    parameter int IDW     = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_LINES-1:0]        irq_in,
    input  logic [N_LINES-1:0]        en_set,
    input  logic [N_LINES-1:0]        en_clr,
    input  logic [N_LINES-1:0]        pd_set,
    input  logic [N_LINES-1:0]        pd_clr,
    input  logic [N_LINES-1:0]        prio_we,
    input  logic [PRIO_W-1:0]         prio_wdata,
    input  logic                      ack_valid,
    input  logic [IDW-1:0]            ack_id,
    input  logic                      ret_valid,
    input  logic [IDW-1:0]            ret_id,
    output logic [N_LINES-1:0]        en_q,
    output logic [N_LINES-1:0]        pend_q,
    output logic [N_LINES-1:0]        act_q,
    output logic [N_LINES*PRIO_W-1:0] prio_flat
);
    logic [N_LINES-1:0] prev_q;
    logic [N_LINES-1:0] rise;
    logic [N_LINES-1:0] ack_mask;
    logic [N_LINES-1:0] ret_mask;

    assign rise = irq_in & ~prev_q;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        localparam int LI = i;
        logic [PRIO_W-1:0] prio_q;
        assign ack_mask[i] = ack_valid && (ack_id == LI[IDW-1:0]);
        assign ret_mask[i] = ret_valid && (ret_id == LI[IDW-1:0]);
        assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q;

        // Per-line priority register.
        always_ff @(posedge clk) begin
            if (!rst_n)          prio_q <= '0;
            else if (prio_we[i]) prio_q <= prio_wdata;
        end

        // R1
        edge_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> pend_q[i]);
        // R2
        sw_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pd_set[i] |=> pend_q[i]);
        // R3
        clear_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pd_clr[i] && !rise[i] && !pd_set[i] |=> !pend_q[i]);
        // R4
        entry_moves_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ack_mask[i] && !rise[i] && !pd_set[i] |=> act_q[i] && !pend_q[i]);
        // R6
        return_clears_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ret_mask[i] && !ack_mask[i] |=> !act_q[i]);
    end

    // Edge history of the request inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= irq_in;
    end

    // Enable bits: set and clear words.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | en_set) & ~en_clr;
    end

    // Pending bits: new requests win over clears and entry.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~pd_clr & ~ack_mask) | rise | pd_set;
    end

    // Active bits: entry wins over a return on the same line.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= (act_q & ~ret_mask) | ack_mask;
    end
endmodule

// File: rtl/irq_pick.sv
// Module: picks the lowest priority value among masked lines, ties going to
// the lowest index. Purely combinational; depth grows linearly with N_LINES.
module irq_pick #(
    parameter int N_LINES = 32,
    parameter int PRIO_W  = 8,
    parameter int IDW     = 5
) (
    input  logic [N_LINES-1:0]        mask,
    input  logic [N_LINES*PRIO_W-1:0] prio_flat,
    output logic                      found,
    output logic [IDW-1:0]            id,
    output logic [PRIO_W-1:0]         prio
);
    // Scan from the top index down so equal values settle on the lowest index.
    always_comb begin
        found = 1'b0;
        id    = '0;
        prio  = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (mask[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] <= prio)) begin
                found = 1'b1;
                id    = IDW'(i);
                prio  = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irq_lifecycle_tracker.sv
// Module (top): tracks per-line interrupt lifecycle and offers the best
// enabled pending line to the core when it outranks every active line.
// Assumes N_LINES between 2 and 128 and PRIO_W at most 32.
module irq_lifecycle_tracker
    import irq_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int PRIO_W  = 8,
    localparam int IDW    = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [BUS_DW-1:0]  bus_wdata,
    output logic [BUS_DW-1:0]  bus_rdata,
    input  logic               ack_valid,
    input  logic [IDW-1:0]     ack_id,
    input  logic               ret_valid,
    input  logic [IDW-1:0]     ret_id,
    output logic               irq_req,
    output logic [IDW-1:0]     irq_id,
    output logic [PRIO_W-1:0]  irq_prio
);
    logic [N_LINES-1:0]        en_q, pend_q, act_q;
    logic [N_LINES-1:0]        en_set, en_clr, pd_set, pd_clr, prio_we;
    logic [PRIO_W-1:0]         prio_wdata;
    logic [N_LINES*PRIO_W-1:0] prio_flat;
    logic                      cand_found, act_found;
    logic [IDW-1:0]            act_id_unused;
    logic [PRIO_W-1:0]         act_prio;

    irq_bus_decode #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_decode (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .en_q(en_q), .pend_q(pend_q), .act_q(act_q), .prio_flat(prio_flat),
        .en_set(en_set), .en_clr(en_clr), .pd_set(pd_set), .pd_clr(pd_clr),
        .prio_we(prio_we), .prio_wdata(prio_wdata), .bus_rdata(bus_rdata)
    );

    irq_line_bank #(.N_LINES(N_LINES), .PRIO_W(PRIO_W), .IDW(IDW)) u_bank (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .en_set(en_set), .en_clr(en_clr), .pd_set(pd_set), .pd_clr(pd_clr),
        .prio_we(prio_we), .prio_wdata(prio_wdata),
        .ack_valid(ack_valid), .ack_id(ack_id),
        .ret_valid(ret_valid), .ret_id(ret_id),
        .en_q(en_q), .pend_q(pend_q), .act_q(act_q), .prio_flat(prio_flat)
    );

    irq_pick #(.N_LINES(N_LINES), .PRIO_W(PRIO_W), .IDW(IDW)) u_pick_cand (
        .mask(en_q & pend_q), .prio_flat(prio_flat),
        .found(cand_found), .id(irq_id), .prio(irq_prio)
    );

    irq_pick #(.N_LINES(N_LINES), .PRIO_W(PRIO_W), .IDW(IDW)) u_pick_run (
        .mask(act_q), .prio_flat(prio_flat),
        .found(act_found), .id(act_id_unused), .prio(act_prio)
    );

    // Offer the candidate only when it strictly outranks the running level.
    assign irq_req = cand_found && (!act_found || (irq_prio < act_prio));

    // R9
    req_is_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> en_q[irq_id] && pend_q[irq_id]);
    // R7
    idle_must_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(en_q & pend_q)) && !(|act_q) |-> irq_req);

    for (genvar i = 0; i < N_LINES; i++) begin : g_chk
        // R9
        req_is_best_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req && en_q[i] && pend_q[i] |-> irq_prio <= prio_flat[i*PRIO_W +: PRIO_W]);
        // R10
        req_beats_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req && act_q[i] |-> irq_prio < prio_flat[i*PRIO_W +: PRIO_W]);
    end
endmodule

// File: tb/irq_lifecycle_tracker_test.sv
`timescale 1ns/1ps
module irq_lifecycle_tracker_test;
    localparam int N = 32;
    localparam logic [7:0] A_ENSET = 8'h00, A_ENCLR = 8'h04, A_PDSET = 8'h08,
                           A_PDCLR = 8'h0C, A_ACT = 8'h10, A_PRIO = 8'h80;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [N-1:0] irq_in = '0;
    logic        bus_valid = 0, bus_write = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ack_valid = 0, ret_valid = 0;
    logic [4:0]  ack_id = '0, ret_id = '0;
    logic        irq_req;
    logic [4:0]  irq_id;
    logic [7:0]  irq_prio;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct { logic [31:0] val; string tag; } exp_t;
    exp_t exp_q[$];
    logic rd_seen = 0;

    irq_lifecycle_tracker #(.N_LINES(N), .PRIO_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_valid(ack_valid), .ack_id(ack_id),
        .ret_valid(ret_valid), .ret_id(ret_id),
        .irq_req(irq_req), .irq_id(irq_id), .irq_prio(irq_prio)
    );

    always #4 clk = ~clk;

    // Bench record of which cycles carried a read.
    always @(posedge clk) rd_seen <= bus_valid && !bus_write;

    // Monitor: pops one expectation per completed read and compares.
    always @(negedge clk) begin
        if (rd_seen) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL monitor: read data %h with no expectation", bus_rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (bus_rdata !== e.val) begin
                    n_bad++;
                    $display("FAIL %s: rdata actual %h expected %h", e.tag, bus_rdata, e.val);
                end
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    // Driver: issues a read and queues the value the requirements predict.
    task automatic bus_rd(input logic [7:0] a, input logic [31:0] v, input string tag);
        exp_t e;
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        e.val = v; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic check_req(input logic r, input logic [4:0] id, input string tag);
        n_cmp++;
        if (irq_req !== r || (r && irq_id !== id)) begin
            n_bad++;
            $display("FAIL %s: req/id actual %b/%0d expected %b/%0d", tag, irq_req, irq_id, r, id);
        end
    endtask

    task automatic pulse(input int line);
        @(negedge clk); irq_in[line] = 1;
        @(negedge clk); irq_in[line] = 0;
    endtask

    task automatic enter(input logic [4:0] id);
        @(negedge clk); ack_valid = 1; ack_id = id;
        @(negedge clk); ack_valid = 0;
    endtask

    task automatic leave(input logic [4:0] id);
        @(negedge clk); ret_valid = 1; ret_id = id;
        @(negedge clk); ret_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R12: reset state
        check_req(0, 0, "R12 request after reset");
        bus_rd(A_ENSET, 32'h0, "R12 enable");
        bus_rd(A_PDSET, 32'h0, "R12 pending");
        bus_rd(A_ACT,   32'h0, "R12 active");
        bus_rd(A_PRIO + 8'd5, 32'h0, "R12 priority");

        // R13: priority table
        bus_wr(A_PRIO + 8'd3, 32'hFFFF_FF10);
        bus_wr(A_PRIO + 8'd5, 32'h10);
        bus_wr(A_PRIO + 8'd7, 32'h08);
        bus_wr(A_PRIO + 8'd9, 32'h04);
        bus_rd(A_PRIO + 8'd3, 32'h10, "R13 priority line 3");
        bus_rd(A_PRIO + 8'd7, 32'h08, "R13 priority line 7");

        // R1 / R7: edge while disabled, held level does not re-arm
        @(negedge clk); irq_in[3] = 1;
        bus_rd(A_PDSET, 32'h8, "R1 edge while disabled");
        check_req(0, 0, "R7 disabled line silent");
        bus_wr(A_PDCLR, 32'h8);
        bus_rd(A_PDSET, 32'h0, "R1 held level no re-set");
        @(negedge clk); irq_in[3] = 0;
        pulse(3);
        bus_rd(A_PDCLR, 32'h8, "R11 pending via clear addr");
        bus_wr(A_ENSET, 32'h8);
        check_req(1, 3, "R7 enable with residual pending");
        bus_rd(A_ENCLR, 32'h8, "R11 enable via clear addr");

        // R2 / R11: zero writes and active writes ignored
        bus_wr(A_PDSET, 32'h0);
        bus_wr(A_PDCLR, 32'h0);
        bus_wr(A_ENCLR, 32'h0);
        bus_wr(A_ACT, 32'hFFFF_FFFF);
        bus_rd(A_PDSET, 32'h8, "R2 zero writes keep pending");
        bus_rd(A_ENSET, 32'h8, "R2 zero write keeps enable");
        bus_rd(A_ACT, 32'h0, "R11 active read-only");

        // R2 / R9: software pending, tie and priority order
        bus_wr(A_ENSET, 32'h20);
        bus_wr(A_PDSET, 32'h20);
        check_req(1, 3, "R9 tie goes to lowest index");
        bus_wr(A_ENSET, 32'h80);
        bus_wr(A_PDSET, 32'h80);
        check_req(1, 7, "R9 lowest value wins");
        bus_rd(A_PDSET, 32'hA8, "R2 software set pending");

        // R4 / R10: entry
        enter(7);
        check_req(0, 0, "R10 lower urgency held off");
        bus_rd(A_PDSET, 32'h28, "R4 entry clears pending");
        bus_rd(A_ACT, 32'h80, "R4 entry sets active");

        // R5: repeat request while active
        pulse(7);
        check_req(0, 0, "R10 equal value does not preempt");
        bus_rd(A_PDSET, 32'hA8, "R5 pending again while active");
        bus_rd(A_ACT, 32'h80, "R5 still active");

        // R6: return re-takes the pending line
        leave(7);
        check_req(1, 7, "R6 re-presented after return");
        bus_rd(A_ACT, 32'h0, "R6 return clears active");

        // R10 / R8: nesting and discarding a repeat
        enter(7);
        bus_wr(A_ENSET, 32'h200);
        pulse(9);
        check_req(1, 9, "R10 strictly higher preempts");
        enter(9);
        check_req(0, 0, "R10 nested blocks others");
        bus_rd(A_ACT, 32'h280, "R4 nested active bits");
        pulse(9);
        bus_rd(A_PDSET, 32'h228, "R5 repeat during nested service");
        bus_wr(A_PDCLR, 32'h200);
        leave(9);
        check_req(0, 0, "R8 no second entry after clear");
        bus_rd(A_PDSET, 32'h28, "R8 pending after return");
        leave(7);
        check_req(1, 3, "R6 next line after last return");

        // R3: edge and clear in the same cycle
        @(negedge clk);
        irq_in[11] = 1;
        bus_valid = 1; bus_write = 1; bus_addr = A_PDCLR; bus_wdata = 32'h808;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; irq_in[11] = 0;
        bus_rd(A_PDCLR, 32'h820, "R3 edge beats clear, clear drops line 3");
        check_req(1, 5, "R3 remaining pending line");

        // R7: disable removes the request
        bus_wr(A_ENCLR, 32'h20);
        check_req(0, 0, "R7 disabled pending line silent");
        bus_rd(A_ENSET, 32'h288, "R11 enable after clear-enable");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: %0d reads never returned, expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule